// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Shared Divider Time Bases

This block drives four pulse-width modulated outputs from a small memory-mapped register port. Four 16-bit divider registers each define a time base of 256 duty steps, with every step lasting as many system clocks as the divider value. Each channel picks one of the four dividers through a 2-bit selector. It drives its output high for the first `duty` steps of every 256-step period and low for the rest.

Each channel has three control bits. The output-enable bit gates the pin. The run bit lets the channel's step counter advance, and clearing it stops and zeroes the counter. The bypass bit holds the pin high while the pin is enabled. A write to a channel's duty register, or to the divider that channel currently follows, abandons the period in progress and starts a new one from step zero on the next cycle. Software therefore sees new settings at once and never waits for a period boundary. The output is active high.

Registers sit at byte offsets on 32-bit words. Reads return the last value written, with unimplemented bits reading zero. One synchronous active-high reset clears everything.

Top module: `quad_pwm`

## Requirements
- R1: After reset every register reads zero and all four outputs are low.
- R2: Readback at offset 0x00 gives output-enable in bits [3:0] and bypass in bits [11:8]. Offset 0x04 gives run bits in [3:0]. Offset 0x08+4n gives divider n in bits [15:0]. Offset 0x18+4n gives channel n's duty in bits [7:0] and its divider selector in bits [9:8]. All other bits read zero.
- R3: A read of any other offset, including one not word aligned, returns zero. A write to such an offset changes no register.
- R4: With divider value F (nonzero) and duty D, a running, enabled, unbypassed channel is high for D×F clocks at the start of each period and low for the rest. The period lasts 256×F clocks.
- R5: The selector bits [9:8] of a channel's duty register choose which divider (0 to 3) times that channel.
- R6: While a channel's output-enable and bypass bits are both set, its output is high continuously, whatever its run bit or divider.
- R7: While a channel's output-enable bit is clear, its output is low.
- R8: While a channel's run bit is clear, its counter is held at zero and its unbypassed output is low. Setting the bit starts a fresh period.
- R9: A write to a channel's duty register, or to the divider it currently selects, restarts that channel's period at step zero on the next cycle.
- R10: A channel whose selected divider holds zero is stopped, and its unbypassed output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| addr_i | input | 8 | Byte offset of the register access |
| wdata_i | input | 32 | Write data |
| wr_en_i | input | 1 | Write strobe, one register written per cycle |
| rd_en_i | input | 1 | Read strobe; read data is valid the following cycle |
| rdata_o | output | 32 | Read data, held until the next read |
| pwm_o | output | 4 | Channel outputs, bit n is channel n |

## Verification
The assertions assume three things about the inputs. Reset is applied before the first useful edge. The strobes and address are never unknown. A divider or selector changes only through a write on the register port, because that write is what keeps a channel's prescale count below its divider. The bench drives every input with known values on the falling edge, holds reset for several cycles at the start, and issues at most one register access per cycle. All configuration goes through the same write task, so each divider or selector change arrives together with the restart that the counter bound relies on.

// File: rtl/quad_pwm_pkg.sv
package quad_pwm_pkg;

    localparam int NCH     = 4;
    localparam int NDIV    = 4;
    localparam int DIV_W   = 16;
    localparam int DUTY_W  = 8;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int SEL_W   = $clog2(NDIV);
    localparam int IDX_W   = $clog2((NCH > NDIV) ? NCH : NDIV);
    localparam int BYP_LSB = 8;

    localparam logic [ADDR_W-1:0] OUTCTL_OFS = 8'h00;
    localparam logic [ADDR_W-1:0] RUNCTL_OFS = 8'h04;
    localparam logic [ADDR_W-1:0] DIV_BASE   = 8'h08;
    localparam logic [ADDR_W-1:0] LVL_BASE   = 8'h18;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_OUTCTL,
        RG_RUNCTL,
        RG_DIV,
        RG_LVL
    } rg_kind_e;

    typedef struct packed {
        rg_kind_e           kind;
        logic [IDX_W-1:0]   idx;
    } rg_sel_t;

    typedef struct packed {
        logic [NCH-1:0]                 en;
        logic [NCH-1:0]                 byp;
        logic [NCH-1:0]                 run;
        logic [NDIV-1:0][DIV_W-1:0]     div;
        logic [NCH-1:0][DUTY_W-1:0]     duty;
        logic [NCH-1:0][SEL_W-1:0]      sel;
        logic [DATA_W-1:0]              rdata;
    } regs_t;

    typedef struct packed {
        logic [DIV_W-1:0]  pre;
        logic [DUTY_W-1:0] step;
    } chan_t;

    function automatic rg_sel_t decode(input logic [ADDR_W-1:0] a);
        rg_sel_t r;
        r.kind = RG_NONE;
        r.idx  = '0;
        if (a == OUTCTL_OFS) begin
            r.kind = RG_OUTCTL;
        end else if (a == RUNCTL_OFS) begin
            r.kind = RG_RUNCTL;
        end else begin
            for (int i = 0; i < NDIV; i++) begin
                if (a == DIV_BASE + ADDR_W'(4 * i)) begin
                    r.kind = RG_DIV;
                    r.idx  = IDX_W'(i);
                end
            end
            for (int i = 0; i < NCH; i++) begin
                if (a == LVL_BASE + ADDR_W'(4 * i)) begin
                    r.kind = RG_LVL;
                    r.idx  = IDX_W'(i);
                end
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/quad_pwm_regs.sv
module quad_pwm_regs
    import quad_pwm_pkg::*;
(
    input  logic                            clk_i,
    input  logic                            rst_i,
    input  logic [ADDR_W-1:0]               addr_i,
    input  logic [DATA_W-1:0]               wdata_i,
    input  logic                            wr_en_i,
    input  logic                            rd_en_i,
    output logic [DATA_W-1:0]               rdata_o,
    output logic [NCH-1:0]                  en_o,
    output logic [NCH-1:0]                  byp_o,
    output logic [NCH-1:0]                  run_o,
    output logic [NDIV-1:0][DIV_W-1:0]      div_o,
    output logic [NCH-1:0][DUTY_W-1:0]      duty_o,
    output logic [NCH-1:0][SEL_W-1:0]       sel_o,
    output logic [NDIV-1:0]                 div_wr_o,
    output logic [NCH-1:0]                  lvl_wr_o
);

    regs_t   r_d, r_q;
    rg_sel_t dec;
    logic [DATA_W-1:0] rd_val;

    always_comb begin
        r_d      = r_q;
        dec      = decode(addr_i);
        div_wr_o = '0;
        lvl_wr_o = '0;
        rd_val   = '0;

        case (dec.kind)
            RG_OUTCTL: begin
                rd_val[NCH-1:0]         = r_q.en;
                rd_val[BYP_LSB +: NCH]  = r_q.byp;
            end
            RG_RUNCTL: rd_val[NCH-1:0] = r_q.run;
            RG_DIV:    rd_val[DIV_W-1:0] = r_q.div[dec.idx];
            RG_LVL: begin
                rd_val[DUTY_W-1:0]      = r_q.duty[dec.idx];
                rd_val[DUTY_W +: SEL_W] = r_q.sel[dec.idx];
            end
            default: rd_val = '0;
        endcase

        if (wr_en_i) begin
            case (dec.kind)
                RG_OUTCTL: begin
                    r_d.en  = wdata_i[NCH-1:0];
                    r_d.byp = wdata_i[BYP_LSB +: NCH];
                end
                RG_RUNCTL: r_d.run = wdata_i[NCH-1:0];
                RG_DIV: begin
                    r_d.div[dec.idx]   = wdata_i[DIV_W-1:0];
                    div_wr_o[dec.idx]  = 1'b1;
                end
                RG_LVL: begin
                    r_d.duty[dec.idx]  = wdata_i[DUTY_W-1:0];
                    r_d.sel[dec.idx]   = wdata_i[DUTY_W +: SEL_W];
                    lvl_wr_o[dec.idx]  = 1'b1;
                end
                default: ;
            endcase
        end

        if (rd_en_i) begin
            r_d.rdata = rd_val;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rdata_o = r_q.rdata;
    assign en_o    = r_q.en;
    assign byp_o   = r_q.byp;
    assign run_o   = r_q.run;
    assign div_o   = r_q.div;
    assign duty_o  = r_q.duty;
    assign sel_o   = r_q.sel;

    // R3
    unmapped_wr_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && decode(addr_i).kind == RG_NONE) |=>
            ($stable(r_q.en) && $stable(r_q.byp) && $stable(r_q.run) &&
             $stable(r_q.div) && $stable(r_q.duty) && $stable(r_q.sel)));

endmodule

// File: rtl/quad_pwm_chan.sv
module quad_pwm_chan
    import quad_pwm_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               run_i,
    input  logic               en_i,
    input  logic               byp_i,
    input  logic [DIV_W-1:0]   freq_i,
    input  logic [DUTY_W-1:0]  duty_i,
    input  logic               restart_i,
    output logic               pwm_o
);

    chan_t c_d, c_q;
    logic  freq_live;
    logic  pre_wrap;

    always_comb begin
        c_d       = c_q;
        freq_live = (freq_i != '0);
        pre_wrap  = (c_q.pre == freq_i - DIV_W'(1));
        if (!run_i || restart_i) begin
            c_d = '0;
        end else if (freq_live) begin
            if (pre_wrap) begin
                c_d.pre  = '0;
                c_d.step = c_q.step + DUTY_W'(1);
            end else begin
                c_d.pre  = c_q.pre + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign pwm_o = en_i & (byp_i | (run_i & freq_live & (c_q.step < duty_i)));

    // R8
    cnt_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !run_i |=> (c_q.pre == '0 && c_q.step == '0));

    // R9
    restart_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        restart_i |=> (c_q.pre == '0 && c_q.step == '0));

    // R4
    pre_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (freq_i != '0) |-> (c_q.pre < freq_i));

    // R4
    step_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_i && !restart_i && freq_i != '0 && c_q.pre != freq_i - DIV_W'(1))
            |=> $stable(c_q.step));

endmodule

// File: rtl/quad_pwm.sv
module quad_pwm
    import quad_pwm_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [7:0]         addr_i,
    input  logic [31:0]        wdata_i,
    input  logic               wr_en_i,
    input  logic               rd_en_i,
    output logic [31:0]        rdata_o,
    output logic [3:0]         pwm_o
);

    logic [NCH-1:0]               en_q, byp_q, run_q;
    logic [NDIV-1:0][DIV_W-1:0]   div_q;
    logic [NCH-1:0][DUTY_W-1:0]   duty_q;
    logic [NCH-1:0][SEL_W-1:0]    sel_q;
    logic [NDIV-1:0]              div_wr;
    logic [NCH-1:0]               lvl_wr;

    quad_pwm_regs regs_i (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .addr_i   (addr_i),
        .wdata_i  (wdata_i),
        .wr_en_i  (wr_en_i),
        .rd_en_i  (rd_en_i),
        .rdata_o  (rdata_o),
        .en_o     (en_q),
        .byp_o    (byp_q),
        .run_o    (run_q),
        .div_o    (div_q),
        .duty_o   (duty_q),
        .sel_o    (sel_q),
        .div_wr_o (div_wr),
        .lvl_wr_o (lvl_wr)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic [SEL_W-1:0] pick;
        logic [DIV_W-1:0] freq;
        logic             restart;

        assign pick    = sel_q[c];
        assign freq    = div_q[pick];
        assign restart = lvl_wr[c] | div_wr[pick];

        quad_pwm_chan chan_i (
            .clk_i     (clk_i),
            .rst_i     (rst_i),
            .run_i     (run_q[c]),
            .en_i      (en_q[c]),
            .byp_i     (byp_q[c]),
            .freq_i    (freq),
            .duty_i    (duty_q[c]),
            .restart_i (restart),
            .pwm_o     (pwm_o[c])
        );
    end

endmodule

// File: tb/quad_pwm_tb.sv
`timescale 1ns/1ps
module quad_pwm_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic        wr_en;
    logic        rd_en;
    logic [31:0] rdata;
    logic [3:0]  pwm;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    quad_pwm dut_i (
        .clk_i   (clk),
        .rst_i   (rst),
        .addr_i  (addr),
        .wdata_i (wdata),
        .wr_en_i (wr_en),
        .rd_en_i (rd_en),
        .rdata_o (rdata),
        .pwm_o   (pwm)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a; rd_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    // Samples channel ch for n cycles starting now; returns high count and
    // the index of the first low sample (n if never low).
    task automatic measure(input int ch, input int n, output int highs, output int first_low);
        highs = 0; first_low = n;
        for (int i = 0; i < n; i++) begin
            if (pwm[ch]) highs++;
            else if (first_low == n) first_low = i;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check(pwm == 4'h0, "R1 outputs after reset", pwm, 0);
        rd(8'h00, d); check(d == 0, "R1 out-control reg", d, 0);
        rd(8'h04, d); check(d == 0, "R1 run reg", d, 0);
        for (int i = 0; i < 4; i++) begin
            rd(8'(8'h08 + 4 * i), d); check(d == 0, "R1 divider reg", d, 0);
            rd(8'(8'h18 + 4 * i), d); check(d == 0, "R1 duty reg", d, 0);
        end
    endtask

    task automatic t_readback();
        logic [31:0] d;
        wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, d); check(d == 32'h0F0F, "R2 out-control bits", d, 32'h0F0F);
        wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, d); check(d == 32'h000F, "R2 run bits", d, 32'h000F);
        wr(8'h0C, 32'h1234_ABCD); rd(8'h0C, d); check(d == 32'hABCD, "R2 divider 1", d, 32'hABCD);
        wr(8'h20, 32'hFFFF_FFFF); rd(8'h20, d); check(d == 32'h03FF, "R2 duty 2 with selector", d, 32'h03FF);
        wr(8'h00, 0); wr(8'h04, 0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        wr(8'h30, 32'hFFFF_FFFF);
        wr(8'h0D, 32'h0000_5555);
        wr(8'h06, 32'hFFFF_FFFF);
        rd(8'h30, d); check(d == 0, "R3 read unmapped 0x30", d, 0);
        rd(8'h0D, d); check(d == 0, "R3 read misaligned 0x0D", d, 0);
        rd(8'h0C, d); check(d == 32'hABCD, "R3 divider 1 untouched", d, 32'hABCD);
        rd(8'h04, d); check(d == 0, "R3 run reg untouched", d, 0);
        rd(8'h00, d); check(d == 0, "R3 out-control untouched", d, 0);
        wr(8'h0C, 0); wr(8'h20, 0);
    endtask

    task automatic t_duty();
        int h, fl;
        wr(8'h08, 2);               // divider 0 = 2
        wr(8'h04, 32'h1);           // run ch0
        wr(8'h00, 32'h1);           // enable ch0
        wr(8'h18, 32'h0000_0005);   // ch0 duty 5, selector 0
        measure(0, 512, h, fl);
        check(h == 10, "R4 high clocks, first period", h, 10);
        check(fl == 10, "R4 high phase at period start", fl, 10);
        measure(0, 512, h, fl);
        check(h == 10 && fl == 10, "R4 second period identical", h, 10);
    endtask

    task automatic t_select();
        int h, fl;
        wr(8'h10, 3);                     // divider 2 = 3
        wr(8'h04, 32'h3);
        wr(8'h00, 32'h3);
        wr(8'h1C, (2 << 8) | 128);        // ch1 duty 128, selector 2
        measure(1, 768, h, fl);
        check(h == 384 && fl == 384, "R5 ch1 follows divider 2", h, 384);
    endtask

    task automatic t_restart();
        int h, fl;
        repeat (100) @(negedge clk);      // ch0 in its low phase
        check(pwm[0] == 1'b0, "R9 ch0 low before divider write", pwm[0], 0);
        wr(8'h08, 4);                     // selected divider rewritten
        measure(0, 1024, h, fl);
        check(h == 20 && fl == 20, "R9 period restarts on divider write", h, 20);
        repeat (50) @(negedge clk);
        wr(8'h18, 32'h0000_0003);         // duty rewrite mid period
        measure(0, 40, h, fl);
        check(fl == 12, "R9 period restarts on duty write", fl, 12);
        wr(8'h18, 32'h0000_0005);
    endtask

    task automatic t_bypass();
        int h, fl;
        wr(8'h00, 32'h101);
        measure(0, 600, h, fl);
        check(h == 600, "R6 bypass holds high", h, 600);
        wr(8'h04, 32'h0);
        measure(0, 100, h, fl);
        check(h == 100, "R6 bypass with run clear", h, 100);
        wr(8'h00, 32'h100);
        measure(0, 300, h, fl);
        check(h == 0, "R7 enable clear forces low", h, 0);
    endtask

    task automatic t_run();
        int h, fl;
        wr(8'h00, 32'h1);
        measure(0, 300, h, fl);
        check(h == 0, "R8 run clear output low", h, 0);
        wr(8'h04, 32'h1);
        measure(0, 1024, h, fl);
        check(h == 20 && fl == 20, "R8 fresh period on run set", h, 20);
    endtask

    task automatic t_zero_div();
        int h, fl;
        wr(8'h08, 0);
        measure(0, 300, h, fl);
        check(h == 0, "R10 zero divider stops channel", h, 0);
        wr(8'h00, 32'h101);
        measure(0, 50, h, fl);
        check(h == 50, "R10 bypass still high on zero divider", h, 50);
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
                $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
                $finish;
            end
        end
    end

    initial begin
        rst = 1'b1; addr = '0; wdata = '0; wr_en = 1'b0; rd_en = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_readback();
        t_unmapped();
        t_duty();
        t_select();
        t_restart();
        t_bypass();
        t_run();
        t_zero_div();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule